// File: doc/BRIEF.md
# TLB Access-Rights and Fault Checker

This combinational block sits after a TLB lookup. It takes the looked-up entry's protection fields, the privilege level of the current access and the kind of access, and returns two things. The first is the permission mask that a translation cache may record for the page. The second is the single exception, if there is one, that the access must raise. The entry carries two privilege thresholds, a rights type, an access identifier and three status bits: dirty, break and reference. The checker also takes a protection-identifier enable and a small set of protection-identifier registers.

Privilege numbers grow as trust falls, so level 0 is the most privileged. The rights type selects which of read, write and execute are offered. The two thresholds set the privilege levels at which each one is granted. A matching protection identifier takes write away. The status bits then add faults in a fixed order, and a later check replaces an earlier one. A probe access returns the mask and raises no rights or status fault.

Top module: `tlb_rights_check`

## Requirements
- R1: Read is granted when priv ≤ pl1 and write when priv ≤ pl2. Execute is granted only when pl2 ≤ priv ≤ pl1. The mask bits are bit0 read, bit1 write and bit2 execute.
- R2: Rights type 0 offers read. Type 1 offers read and write. Type 2 offers read and execute. Type 3 offers all three. Types 4 to 7 offer execute only. Each offered right is then gated by R1.
- R3: When the lookup misses (hit low), the mask is 0. The code is 1 (instruction TLB miss) for a fetch and 2 (data TLB miss) for any other access type, probe included. Access type encoding: 0 probe, 1 read, 2 write, 3 fetch.
- R4: A probe access on a hit raises no exception, and its mask reflects only R1, R2 and R6. The dirty, break and reference bits do not change it.
- R5: If the mask bit for a read, write or fetch is clear, the code is 4 (instruction protection) for a fetch and 5 (data access rights) otherwise. The mask is returned unchanged.
- R6: With a nonzero access id and the enable high, the key {id, 1'b1} is compared with every protection-id register. A match in any of them clears write from the mask. A write access then takes code 3 (data protection-id fault).
- R7: An access id of zero, or the enable held low, disables protection-id matching.
- R8: Dirty bit clear clears write from the mask, and a write then takes code 6 (dirty fault).
- R9: Break bit set clears write from the mask, and a write then takes code 7 (data break). This replaces a dirty fault.
- R10: Reference bit set leaves only execute in the mask, and a read or write then takes code 8 (page reference). This replaces dirty and break faults. A fetch raises no fault from this bit.
- R11: The exception valid flag is high exactly when the code is nonzero, and the code is 0 when the access succeeds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| hit_i | input | 1 | TLB lookup found an entry |
| acc_i | input | 2 | Access type: 0 probe, 1 read, 2 write, 3 fetch |
| priv_i | input | PRIV_W | Current privilege level |
| pl1_i | input | PRIV_W | Read/execute outer threshold |
| pl2_i | input | PRIV_W | Write/execute inner threshold |
| art_i | input | ART_W | Rights type |
| dirty_i | input | 1 | Entry dirty bit |
| brk_i | input | 1 | Entry break bit |
| ref_i | input | 1 | Entry reference-trap bit |
| aid_i | input | AID_W | Entry access identifier |
| pid_en_i | input | 1 | Protection-id checking enable |
| pid_i | input | NUM_PID x (AID_W+1) | Protection-id registers |
| mask_o | output | 3 | Granted rights: bit0 R, bit1 W, bit2 X |
| exc_code_o | output | 4 | Exception code, 0 when none |
| exc_valid_o | output | 1 | An exception is raised |

## Verification
A table of directed vectors covers three kinds of case. One is a miss for each access type. Another is each rights type placed at the edges of the privilege windows. The last is each fault combination, including the overlaps that show which of dirty, break and reference wins. An exhaustive sweep crosses every privilege, both thresholds, every rights type, every access type and every status-bit setting, and compares each result with an independent model. This separates faults in the window comparisons from faults in the priority order. Directed cases cover a key match in each protection-id register, a zero access id with a register that would match, and a match with the enable low. These show that the gating on R7 works on its own and is not hidden by the rights.

// File: rtl/tlb_rights_pkg.sv
package tlb_rights_pkg;
  localparam int unsigned MASK_W = 3;
  localparam int unsigned BIT_R  = 0;
  localparam int unsigned BIT_W  = 1;
  localparam int unsigned BIT_X  = 2;

  typedef enum logic [1:0] {
    ACC_PROBE = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2,
    ACC_FETCH = 2'd3
  } acc_e;

  typedef enum logic [3:0] {
    EXC_NONE    = 4'd0,
    EXC_IMISS   = 4'd1,
    EXC_DMISS   = 4'd2,
    EXC_DPID    = 4'd3,
    EXC_IPROT   = 4'd4,
    EXC_DRIGHTS = 4'd5,
    EXC_DIRTY   = 4'd6,
    EXC_DBRK    = 4'd7,
    EXC_PREF    = 4'd8
  } exc_e;
endpackage

// File: rtl/tlb_rights_decode.sv
module tlb_rights_decode
  import tlb_rights_pkg::*;
#(
  parameter int unsigned PRIV_W = 2,
  parameter int unsigned ART_W  = 3
) (
  input  logic [PRIV_W-1:0] priv_i,
  input  logic [PRIV_W-1:0] pl1_i,
  input  logic [PRIV_W-1:0] pl2_i,
  input  logic [ART_W-1:0]  art_i,
  output logic [MASK_W-1:0] mask_o
);
  localparam logic [ART_W-1:0] ART_XONLY = ART_W'(4);

  logic rd_ok, wr_ok, ex_ok;

  assign rd_ok = (priv_i <= pl1_i);
  assign wr_ok = (priv_i <= pl2_i);
  assign ex_ok = (pl2_i <= priv_i) && (priv_i <= pl1_i);

  always_comb begin
    mask_o = '0;
    if (art_i >= ART_XONLY) begin
      mask_o[BIT_X] = ex_ok;
    end else begin
      mask_o[BIT_R] = rd_ok;
      mask_o[BIT_W] = wr_ok & art_i[0];
      mask_o[BIT_X] = ex_ok & art_i[1];
    end
  end

  // execute window lies inside the read window for mixed types
  always_comb begin
    if (!$isunknown({priv_i, pl1_i, pl2_i, art_i})) begin
      p_exec_needs_read_r1: assert (!(mask_o[BIT_X] && art_i < ART_XONLY) || mask_o[BIT_R])
        else $error("R1: execute granted without read");
      p_xonly_type_r2: assert (!(art_i >= ART_XONLY) || (mask_o[BIT_R] == 1'b0 && mask_o[BIT_W] == 1'b0))
        else $error("R2: execute-only type offers read or write");
    end
  end
endmodule

// File: rtl/tlb_pid_match.sv
module tlb_pid_match #(
  parameter int unsigned AID_W   = 31,
  parameter int unsigned NUM_PID = 4
) (
  input  logic [AID_W-1:0]              aid_i,
  input  logic                          en_i,
  input  logic [NUM_PID-1:0][AID_W:0]   pid_i,
  output logic                          hit_o
);
  logic [AID_W:0]     key;
  logic [NUM_PID-1:0] eq;

  assign key = {aid_i, 1'b1};

  for (genvar g = 0; g < NUM_PID; g++) begin : g_cmp
    assign eq[g] = (pid_i[g] == key);
  end

  // id zero marks a public page
  assign hit_o = en_i && (aid_i != '0) && (|eq);
endmodule

// File: rtl/tlb_fault_resolve.sv
module tlb_fault_resolve
  import tlb_rights_pkg::*;
(
  input  logic              hit_i,
  input  acc_e              acc_i,
  input  logic [MASK_W-1:0] rights_i,
  input  logic              pid_hit_i,
  input  logic              dirty_i,
  input  logic              brk_i,
  input  logic              ref_i,
  output logic [MASK_W-1:0] mask_o,
  output exc_e              code_o,
  output logic              valid_o
);
  logic req_ok;
  logic is_fetch, is_write;

  assign is_fetch = (acc_i == ACC_FETCH);
  assign is_write = (acc_i == ACC_WRITE);

  always_comb begin
    mask_o = rights_i;
    code_o = EXC_NONE;
    req_ok = 1'b1;
    if (pid_hit_i) mask_o[BIT_W] = 1'b0;
    unique case (acc_i)
      ACC_READ:  req_ok = mask_o[BIT_R];
      ACC_WRITE: req_ok = mask_o[BIT_W];
      ACC_FETCH: req_ok = mask_o[BIT_X];
      default:   req_ok = 1'b1;
    endcase

    if (!hit_i) begin
      mask_o = '0;
      code_o = is_fetch ? EXC_IMISS : EXC_DMISS;
    end else if (pid_hit_i && is_write) begin
      code_o = EXC_DPID;
    end else if (acc_i == ACC_PROBE) begin
      code_o = EXC_NONE;
    end else if (!req_ok) begin
      code_o = is_fetch ? EXC_IPROT : EXC_DRIGHTS;
    end else begin
      // later checks take priority over earlier ones
      if (!dirty_i) begin
        if (is_write) code_o = EXC_DIRTY;
        mask_o[BIT_W] = 1'b0;
      end
      if (brk_i) begin
        if (is_write) code_o = EXC_DBRK;
        mask_o[BIT_W] = 1'b0;
      end
      if (ref_i) begin
        if (!is_fetch) code_o = EXC_PREF;
        mask_o = mask_o & (MASK_W'(1) << BIT_X);
      end
    end
  end

  assign valid_o = (code_o != EXC_NONE);

  always_comb begin
    if (!$isunknown({hit_i, acc_i, rights_i, pid_hit_i, dirty_i, brk_i, ref_i})) begin
      p_miss_code_r3: assert (hit_i || (mask_o == '0 && (code_o == EXC_IMISS || code_o == EXC_DMISS)))
        else $error("R3: miss not reported");
      p_probe_quiet_r4: assert (!(hit_i && acc_i == ACC_PROBE) || !valid_o)
        else $error("R4: probe raised a fault");
      p_dirty_src_r8: assert (code_o != EXC_DIRTY || (is_write && !dirty_i && !brk_i && !ref_i))
        else $error("R8: dirty fault without its cause");
      p_brk_src_r9: assert (code_o != EXC_DBRK || (is_write && brk_i && !ref_i))
        else $error("R9: break fault without its cause");
      p_ref_exec_only_r10: assert (!(hit_i && ref_i && acc_i != ACC_PROBE && req_ok && !(pid_hit_i && is_write))
                                   || (mask_o[BIT_R] == 1'b0 && mask_o[BIT_W] == 1'b0))
        else $error("R10: reference bit left read or write");
    end
  end
endmodule

// File: rtl/tlb_rights_check.sv
module tlb_rights_check
  import tlb_rights_pkg::*;
#(
  parameter int unsigned PRIV_W  = 2,
  parameter int unsigned ART_W   = 3,
  parameter int unsigned AID_W   = 31,
  parameter int unsigned NUM_PID = 4
) (
  input  logic                        hit_i,
  input  logic [1:0]                  acc_i,
  input  logic [PRIV_W-1:0]           priv_i,
  input  logic [PRIV_W-1:0]           pl1_i,
  input  logic [PRIV_W-1:0]           pl2_i,
  input  logic [ART_W-1:0]            art_i,
  input  logic                        dirty_i,
  input  logic                        brk_i,
  input  logic                        ref_i,
  input  logic [AID_W-1:0]            aid_i,
  input  logic                        pid_en_i,
  input  logic [NUM_PID-1:0][AID_W:0] pid_i,
  output logic [2:0]                  mask_o,
  output logic [3:0]                  exc_code_o,
  output logic                        exc_valid_o
);
  logic [MASK_W-1:0] rights;
  logic              pid_hit;
  exc_e              code;

  tlb_rights_decode #(.PRIV_W(PRIV_W), .ART_W(ART_W)) u_decode (
    .priv_i (priv_i),
    .pl1_i  (pl1_i),
    .pl2_i  (pl2_i),
    .art_i  (art_i),
    .mask_o (rights)
  );

  tlb_pid_match #(.AID_W(AID_W), .NUM_PID(NUM_PID)) u_pid (
    .aid_i (aid_i),
    .en_i  (pid_en_i),
    .pid_i (pid_i),
    .hit_o (pid_hit)
  );

  tlb_fault_resolve u_resolve (
    .hit_i     (hit_i),
    .acc_i     (acc_e'(acc_i)),
    .rights_i  (rights),
    .pid_hit_i (pid_hit),
    .dirty_i   (dirty_i),
    .brk_i     (brk_i),
    .ref_i     (ref_i),
    .mask_o    (mask_o),
    .code_o    (code),
    .valid_o   (exc_valid_o)
  );

  assign exc_code_o = code;

  always_comb begin
    if (!$isunknown({hit_i, pid_hit, mask_o})) begin
      p_pid_strip_r6: assert (!(hit_i && pid_hit) || !mask_o[BIT_W])
        else $error("R6: matching protection id left write");
    end
  end
endmodule

// File: tb/tlb_rights_check_tb.sv
module tlb_rights_check_tb;
  localparam int AID_W   = 31;
  localparam int NUM_PID = 4;
  localparam int NVEC    = 20;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic                        hit;
  logic [1:0]                  acc;
  logic [1:0]                  priv, pl1, pl2;
  logic [2:0]                  art;
  logic                        dirty, brk, rfb;
  logic [AID_W-1:0]            aid;
  logic                        pid_en;
  logic [NUM_PID-1:0][AID_W:0] pid;
  logic [2:0]                  mask;
  logic [3:0]                  code;
  logic                        valid;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 0;

  tlb_rights_check #(.PRIV_W(2), .ART_W(3), .AID_W(AID_W), .NUM_PID(NUM_PID)) u_dut (
    .hit_i(hit), .acc_i(acc), .priv_i(priv), .pl1_i(pl1), .pl2_i(pl2), .art_i(art),
    .dirty_i(dirty), .brk_i(brk), .ref_i(rfb), .aid_i(aid), .pid_en_i(pid_en),
    .pid_i(pid), .mask_o(mask), .exc_code_o(code), .exc_valid_o(valid)
  );

  // {hit,acc,priv,pl1,pl2,art,d,b,t,pm,pen,mask,code}
  function automatic logic [23:0] mk(int h, int a, int p, int p1, int p2, int ty,
                                     int d, int b, int t, int pm, int pen, int m, int c);
    return {h[0], a[1:0], p[1:0], p1[1:0], p2[1:0], ty[2:0], d[0], b[0], t[0],
            pm[0], pen[0], m[2:0], c[3:0]};
  endfunction

  localparam logic [23:0] VEC [NVEC] = '{
    mk(0,1,0,3,3,1,1,0,0,0,0,0,2),  // R3 miss read
    mk(0,3,0,3,3,1,1,0,0,0,0,0,1),  // R3 miss fetch
    mk(0,0,0,3,3,1,1,0,0,0,0,0,2),  // R3 miss probe
    mk(1,1,0,3,3,1,1,0,0,0,0,3,0),  // R1 R2 read/write page
    mk(1,2,2,1,1,3,1,0,0,0,0,0,5),  // R1 R5 outside every window
    mk(1,3,1,2,0,2,1,0,0,0,0,5,0),  // R1 R2 exec window hit
    mk(1,3,3,2,0,2,1,0,0,0,0,0,4),  // R5 fetch beyond window
    mk(1,1,1,2,0,4,1,0,0,0,0,4,5),  // R2 exec-only type read
    mk(1,2,0,3,3,1,1,0,0,1,1,1,3),  // R6 write with pid match
    mk(1,1,0,3,3,1,1,0,0,1,1,1,0),  // R6 read with pid match
    mk(1,2,0,3,3,1,1,0,0,1,0,3,0),  // R7 enable low
    mk(1,2,0,3,3,1,0,0,0,0,0,1,6),  // R8 dirty clear
    mk(1,2,0,3,3,1,0,1,0,0,0,1,7),  // R9 break over dirty
    mk(1,2,0,3,3,1,0,1,1,0,0,0,8),  // R10 reference over break
    mk(1,1,1,2,0,3,1,0,1,0,0,4,8),  // R10 read with reference
    mk(1,3,1,2,0,3,1,0,1,0,0,4,0),  // R10 fetch with reference
    mk(1,0,0,3,3,3,0,0,1,0,0,3,0),  // R4 probe ignores status bits
    mk(1,0,0,3,3,1,1,0,0,1,1,1,0),  // R4 R6 probe with pid match
    mk(1,2,0,3,3,1,1,1,0,0,0,1,7),  // R9 break alone
    mk(1,1,0,3,3,1,0,0,0,0,0,1,0)   // R8 read with dirty clear
  };

  // independent model of R1..R11; returns {mask, code}
  function automatic logic [6:0] model(logic h, logic [1:0] a, logic [1:0] p,
                                       logic [1:0] p1, logic [1:0] p2, logic [2:0] ty,
                                       logic d, logic b, logic t, logic pm);
    logic r, w, x, need;
    logic [2:0] m;
    logic [3:0] c;
    if (!h) return {3'b000, (a == 2'd3) ? 4'd1 : 4'd2};
    r = (p <= p1);
    w = (p <= p2);
    x = (p2 <= p) && (p <= p1);
    case (ty)
      3'd0:    m = {1'b0, 1'b0, r};
      3'd1:    m = {1'b0, w, r};
      3'd2:    m = {x, 1'b0, r};
      3'd3:    m = {x, w, r};
      default: m = {x, 1'b0, 1'b0};
    endcase
    c = 4'd0;
    if (pm) begin
      m[1] = 1'b0;
      if (a == 2'd2) return {m, 4'd3};
    end
    if (a == 2'd0) return {m, c};
    need = (a == 2'd1) ? m[0] : (a == 2'd2) ? m[1] : m[2];
    if (!need) return {m, (a == 2'd3) ? 4'd4 : 4'd5};
    if (!d) begin if (a == 2'd2) c = 4'd6; m[1] = 1'b0; end
    if (b)  begin if (a == 2'd2) c = 4'd7; m[1] = 1'b0; end
    if (t)  begin if (a != 2'd3) c = 4'd8; m = m & 3'b100; end
    return {m, c};
  endfunction

  task automatic set_in(logic h, logic [1:0] a, logic [1:0] p, logic [1:0] p1,
                        logic [1:0] p2, logic [2:0] ty, logic d, logic b, logic t,
                        logic pm, logic pen);
    @(posedge clk);
    hit = h; acc = a; priv = p; pl1 = p1; pl2 = p2; art = ty;
    dirty = d; brk = b; rfb = t;
    aid = AID_W'(5);
    pid = '0;
    pid[2] = pm ? {AID_W'(5), 1'b1} : '0;
    pid_en = pen;
  endtask

  task automatic check(string tag, logic [2:0] em, logic [3:0] ec);
    @(negedge clk);
    n_run++;
    if (mask !== em || code !== ec || valid !== (ec != 4'd0)) begin
      n_fail++;
      $display("FAIL %s: mask=%b code=%0d valid=%b expected mask=%b code=%0d valid=%b",
               tag, mask, code, valid, em, ec, (ec != 4'd0));
    end
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
  endtask

  initial begin
    hit = 0; acc = 0; priv = 0; pl1 = 0; pl2 = 0; art = 0;
    dirty = 0; brk = 0; rfb = 0; aid = '0; pid_en = 0; pid = '0;
    // idle inputs: probe on a miss reports a data miss (R3)
    check("R3 idle", 3'b000, 4'd2);

    for (int i = 0; i < NVEC; i++) begin
      logic [23:0] v;
      v = VEC[i];
      set_in(v[23], v[22:21], v[20:19], v[18:17], v[16:15], v[14:12],
             v[11], v[10], v[9], v[8], v[7]);
      check($sformatf("vector %0d (R1-R11 table)", i), v[6:4], v[3:0]);
    end

    // exhaustive sweep over R1 R2 R5 R8 R9 R10 R11
    for (int a = 0; a < 4; a++)
      for (int p = 0; p < 4; p++)
        for (int p1 = 0; p1 < 4; p1++)
          for (int p2 = 0; p2 < 4; p2++)
            for (int ty = 0; ty < 8; ty++)
              for (int s = 0; s < 8; s++) begin
                logic [6:0] e;
                e = model(1'b1, a[1:0], p[1:0], p1[1:0], p2[1:0], ty[2:0],
                          s[0], s[1], s[2], 1'b0);
                set_in(1'b1, a[1:0], p[1:0], p1[1:0], p2[1:0], ty[2:0],
                       s[0], s[1], s[2], 1'b0, 1'b0);
                check($sformatf("R1 R2 sweep a=%0d p=%0d pl1=%0d pl2=%0d ty=%0d s=%0d",
                                a, p, p1, p2, ty, s), e[6:4], e[3:0]);
              end

    // R6: key match in each register
    for (int g = 0; g < NUM_PID; g++) begin
      set_in(1'b1, 2'd2, 2'd0, 2'd3, 2'd3, 3'd1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
      pid[g] = {AID_W'(5), 1'b1};
      check($sformatf("R6 match in register %0d", g), 3'b001, 4'd3);
    end

    // R6: even value without the low one does not match
    set_in(1'b1, 2'd2, 2'd0, 2'd3, 2'd3, 3'd1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
    pid[1] = {AID_W'(5), 1'b0};
    check("R6 low bit required", 3'b011, 4'd0);

    // R7: access id zero never matches even if a register holds key 1
    set_in(1'b1, 2'd2, 2'd0, 2'd3, 2'd3, 3'd1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
    aid = '0;
    pid[0] = {{AID_W{1'b0}}, 1'b1};
    check("R7 zero access id", 3'b011, 4'd0);

    // R11 + R3: miss on write
    set_in(1'b0, 2'd2, 2'd0, 2'd3, 2'd3, 3'd3, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1);
    check("R11 miss write", 3'b000, 4'd2);

    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog (all R): run=%0d expected completion", n_run);
      summary();
      $finish;
    end
  end
endmodule